// File: doc/BRIEF.md
# Spill Acquisition Sequencer

This block drives a charge-integrating front-end chip through one beam spill. A spill trigger starts a fixed run of integration periods. Each period is an integrate phase followed by a preamplifier reset phase. The pipeline is clocked twice per period, and the discriminator reset is pulsed once, inside the reset phase. A fixed post-spill wait follows the last period. After it, the block steps the analogue output multiplexer through every stored slice and channel and captures one ADC word per step.

While the periods run, every rising edge on a discriminator line is stamped with the tick count since the trigger. The stamp is queued with the line number. Timestamp records and sample records leave the block on a single 32-bit record stream, one record per tick at most. A trigger that arrives while a spill is still in progress has no effect on the sequence, and it sets a sticky error flag.

Top module: `spill_acq_sequencer`

## Requirements
- R1: After the tick that samples an accepted trigger, `preReset` is low for INTEG_TICKS ticks and then high for RESET_TICKS ticks, repeated for N_PERIODS periods. It is low at every other time.
- R2: `plnClk` is a one-tick pulse at phase 0 and at phase (INTEG_TICKS+RESET_TICKS)/2 of every period. That gives two pulses per period and none outside the periods.
- R3: `digReset` is a one-tick pulse at phase INTEG_TICKS+RESET_TICKS/2 of each period, so it is only ever high while `preReset` is high.
- R4: POST_TICKS ticks after the last period, readout runs for 2*N_PERIODS*N_CHAN steps of MUX_DIV ticks each. `muxClk` is high in the first MUX_DIV/2 ticks of each step. `busy` is high from the tick after the trigger until readout ends.
- R5: On the last tick of each readout step, `adcData` is captured. One tick later a sample record appears: bits 31:16 hold the slice index, bit 15 is 0, bits 14:10 hold the channel index, and bits 9:0 hold the ADC word. Channel runs fastest.
- R6: A rising edge on discriminator line L, sampled during the periods, produces a timestamp record. Its bits 31:16 hold the tick count since the trigger (0 in the first tick after the trigger), bit 15 is 1, bits 14:10 hold L, and bits 9:0 are 0.
- R7: Discriminator edges sampled outside the periods produce no record.
- R8: Edges on several lines in the same tick are emitted one per tick, lowest line first. The first record goes out two ticks after the edge appears at the input.
- R9: A trigger while `busy` is high leaves the sequence unchanged. It sets `busyErr`, which stays high until reset.
- R10: During and after reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock (400 MHz nominal) |
| rstN | input | 1 | Active-low synchronous reset |
| spillTrig | input | 1 | Spill start request |
| discIn | input | NUM_DISC | Discriminator lines from the chip |
| adcData | input | 10 | ADC sample word |
| preReset | output | 1 | Preamplifier reset phase |
| plnClk | output | 1 | Pipeline clock pulse |
| digReset | output | 1 | Discriminator reset pulse |
| muxClk | output | 1 | Output multiplexer clock |
| busy | output | 1 | Spill in progress |
| busyErr | output | 1 | Sticky retrigger error |
| recValid | output | 1 | Record strobe |
| recData | output | 32 | Record word |

## Verification
The bench builds the block with 6-tick integrate, 3-tick reset, 3 periods, a 6-tick post wait, 4 readout channels, 4-tick mux steps and 4 discriminator lines. With these values a whole spill, readout included, lasts about 130 ticks. Every output can therefore be compared on every tick across every phase boundary, including hits on the last acquisition tick and the first post-spill tick, and a retrigger in the middle of readout.

// File: rtl/spill_seq_pkg.sv
package spill_seq_pkg;
  localparam int REC_W = 32;
  localparam int ADC_W = 10;
  localparam int IDX_W = 5;
  localparam int TS_W  = 16;

  typedef enum logic [1:0] {ST_IDLE, ST_ACQ, ST_POST, ST_READ} seqState_t;

  typedef struct packed {
    logic             spillStart;
    logic             hitEnable;
    logic             capture;
    logic [IDX_W-1:0] chan;
    logic [TS_W-1:0]  slice;
  } ctlStrobes_t;
endpackage

// File: rtl/spill_seq_ctrl.sv
module spill_seq_ctrl
  import spill_seq_pkg::*;
#(
  parameter int INTEG_TICKS = 130,
  parameter int RESET_TICKS = 30,
  parameter int N_PERIODS   = 23,
  parameter int POST_TICKS  = 16,
  parameter int N_CHAN      = 32,
  parameter int MUX_DIV     = 40
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        spillTrig,
  output logic        preReset,
  output logic        plnClk,
  output logic        digReset,
  output logic        muxClk,
  output logic        busy,
  output logic        busyErr,
  output ctlStrobes_t strb
);
  localparam int PERIOD    = INTEG_TICKS + RESET_TICKS;
  localparam int HALF      = PERIOD / 2;
  localparam int DIG_PHASE = INTEG_TICKS + RESET_TICKS / 2;
  localparam int N_SLICES  = 2 * N_PERIODS;
  localparam int PH_W  = $clog2(PERIOD + 1);
  localparam int PER_W = $clog2(N_PERIODS + 1);
  localparam int PST_W = $clog2(POST_TICKS + 1);
  localparam int DIV_W = $clog2(MUX_DIV + 1);
  localparam int CH_W  = $clog2(N_CHAN + 1);
  localparam int SL_W  = $clog2(N_SLICES + 1);

  seqState_t        state;
  logic [PH_W-1:0]  phase;
  logic [PER_W-1:0] period;
  logic [PST_W-1:0] waitCnt;
  logic [DIV_W-1:0] div;
  logic [CH_W-1:0]  chan;
  logic [SL_W-1:0]  slice;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      phase   <= '0;
      period  <= '0;
      waitCnt <= '0;
      div     <= '0;
      chan    <= '0;
      slice   <= '0;
      busyErr <= 1'b0;
    end else begin
      if (spillTrig && state != ST_IDLE) busyErr <= 1'b1;
      case (state)
        ST_IDLE: if (spillTrig) begin
          state  <= ST_ACQ;
          phase  <= '0;
          period <= '0;
        end
        ST_ACQ: if (phase == PH_W'(PERIOD - 1)) begin
          phase <= '0;
          if (period == PER_W'(N_PERIODS - 1)) begin
            state   <= ST_POST;
            waitCnt <= '0;
          end else period <= period + 1'b1;
        end else phase <= phase + 1'b1;
        ST_POST: if (waitCnt == PST_W'(POST_TICKS - 1)) begin
          state <= ST_READ;
          div   <= '0;
          chan  <= '0;
          slice <= '0;
        end else waitCnt <= waitCnt + 1'b1;
        ST_READ: if (div == DIV_W'(MUX_DIV - 1)) begin
          div <= '0;
          if (chan == CH_W'(N_CHAN - 1)) begin
            chan <= '0;
            if (slice == SL_W'(N_SLICES - 1)) state <= ST_IDLE;
            else slice <= slice + 1'b1;
          end else chan <= chan + 1'b1;
        end else div <= div + 1'b1;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    preReset = (state == ST_ACQ) && (phase >= PH_W'(INTEG_TICKS));
    plnClk   = (state == ST_ACQ) && (phase == '0 || phase == PH_W'(HALF));
    digReset = (state == ST_ACQ) && (phase == PH_W'(DIG_PHASE));
    muxClk   = (state == ST_READ) && (div < DIV_W'(MUX_DIV / 2));
    busy     = (state != ST_IDLE);
    strb.spillStart = (state == ST_IDLE) && spillTrig;
    strb.hitEnable  = (state == ST_ACQ);
    strb.capture    = (state == ST_READ) && (div == DIV_W'(MUX_DIV - 1));
    strb.chan       = IDX_W'(chan);
    strb.slice      = TS_W'(slice);
  end

  assert_dig_inside_reset_R3: assert property (@(posedge clk) disable iff (!rstN)
    digReset |-> preReset);
  assert_pln_single_tick_R2: assert property (@(posedge clk) disable iff (!rstN)
    plnClk |=> !plnClk);
  assert_retrigger_flags_R9: assert property (@(posedge clk) disable iff (!rstN)
    (spillTrig && busy) |=> busyErr);
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    busyErr |=> busyErr);
endmodule

// File: rtl/spill_seq_datapath.sv
module spill_seq_datapath
  import spill_seq_pkg::*;
#(
  parameter int NUM_DISC = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobes_t         strb,
  input  logic [NUM_DISC-1:0] discIn,
  input  logic [ADC_W-1:0]    adcData,
  output logic                recValid,
  output logic [REC_W-1:0]    recData
);
  logic [NUM_DISC-1:0] discPrev, pending, rise, grant;
  logic [TS_W-1:0]     stamps [NUM_DISC];
  logic [TS_W-1:0]     tsCnt;
  logic [IDX_W-1:0]    sel;
  logic                found;

  assign rise = discIn & ~discPrev;

  always_comb begin
    grant = '0;
    sel   = '0;
    found = 1'b0;
    for (int i = 0; i < NUM_DISC; i++) begin
      if (pending[i] && !found) begin
        found    = 1'b1;
        sel      = IDX_W'(i);
        grant[i] = !strb.capture;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      discPrev <= '0;
      pending  <= '0;
      tsCnt    <= '0;
      recValid <= 1'b0;
      recData  <= '0;
      for (int i = 0; i < NUM_DISC; i++) stamps[i] <= '0;
    end else begin
      discPrev <= discIn;
      tsCnt    <= strb.spillStart ? '0 : tsCnt + 1'b1;
      recValid <= 1'b0;
      if (strb.capture) begin
        recValid <= 1'b1;
        recData  <= {strb.slice, 1'b0, strb.chan, adcData};
      end else if (found) begin
        recValid <= 1'b1;
        recData  <= {stamps[sel], 1'b1, sel, {ADC_W{1'b0}}};
      end
      for (int i = 0; i < NUM_DISC; i++) begin
        if (strb.hitEnable && rise[i] && !pending[i]) begin
          pending[i] <= 1'b1;
          stamps[i]  <= tsCnt;
        end else if (grant[i]) begin
          pending[i] <= 1'b0;
        end
      end
    end
  end

  assert_drained_before_capture_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |-> (pending == '0));
  assert_sample_record_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> (recValid && !recData[15]));
endmodule

// File: rtl/spill_acq_sequencer.sv
module spill_acq_sequencer
  import spill_seq_pkg::*;
#(
  parameter int INTEG_TICKS = 130,
  parameter int RESET_TICKS = 30,
  parameter int N_PERIODS   = 23,
  parameter int POST_TICKS  = 16,
  parameter int N_CHAN      = 32,
  parameter int MUX_DIV     = 40,
  parameter int NUM_DISC    = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                spillTrig,
  input  logic [NUM_DISC-1:0] discIn,
  input  logic [9:0]          adcData,
  output logic                preReset,
  output logic                plnClk,
  output logic                digReset,
  output logic                muxClk,
  output logic                busy,
  output logic                busyErr,
  output logic                recValid,
  output logic [31:0]         recData
);
  ctlStrobes_t strb;

  spill_seq_ctrl #(
    .INTEG_TICKS(INTEG_TICKS), .RESET_TICKS(RESET_TICKS), .N_PERIODS(N_PERIODS),
    .POST_TICKS(POST_TICKS), .N_CHAN(N_CHAN), .MUX_DIV(MUX_DIV)
  ) ctrl (
    .clk(clk), .rstN(rstN), .spillTrig(spillTrig), .preReset(preReset),
    .plnClk(plnClk), .digReset(digReset), .muxClk(muxClk), .busy(busy),
    .busyErr(busyErr), .strb(strb)
  );

  spill_seq_datapath #(.NUM_DISC(NUM_DISC)) dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .discIn(discIn), .adcData(adcData),
    .recValid(recValid), .recData(recData)
  );
endmodule

// File: tb/spill_acq_sequencer_test.sv
module spill_acq_sequencer_test;
  localparam int CLK_PERIOD = 10;
  localparam int INTEG = 6, RST = 3, NPER = 3, POST = 6, NCH = 4, DIV = 4, NDISC = 4;
  localparam int PER = INTEG + RST;
  localparam int ACQ_LAST = NPER * PER - 1;
  localparam int READ_FIRST = NPER * PER + POST;
  localparam int N_SAMPLES = 2 * NPER * NCH;
  localparam int READ_LAST = READ_FIRST + N_SAMPLES * DIV - 1;
  localparam int N_HITS = 7;
  // hit vectors: line, tick it goes high, tick its record is expected (-1: none)
  localparam int HIT_LINE [N_HITS] = '{1, 3, 0, 2, 3, 1, 0};
  localparam int HIT_AT   [N_HITS] = '{2, 2, 10, 25, 26, 27, 30};
  localparam int HIT_EXPK [N_HITS] = '{4, 5, 12, 27, 28, -1, -1};

  logic clk = 0, rstN = 0, spillTrig = 0;
  logic [NDISC-1:0] discIn = '0;
  logic [9:0] adcData = '0;
  logic preReset, plnClk, digReset, muxClk, busy, busyErr, recValid;
  logic [31:0] recData;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  spill_acq_sequencer #(
    .INTEG_TICKS(INTEG), .RESET_TICKS(RST), .N_PERIODS(NPER), .POST_TICKS(POST),
    .N_CHAN(NCH), .MUX_DIV(DIV), .NUM_DISC(NDISC)
  ) uut (
    .clk(clk), .rstN(rstN), .spillTrig(spillTrig), .discIn(discIn), .adcData(adcData),
    .preReset(preReset), .plnClk(plnClk), .digReset(digReset), .muxClk(muxClk),
    .busy(busy), .busyErr(busyErr), .recValid(recValid), .recData(recData)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [9:0] adcOf(input int k);
    return 10'((k * 37 + 5) % 1024);
  endfunction

  task automatic checkIdleOutputs(input string req);
    check(req, {26'b0, preReset, plnClk, digReset, muxClk, busy, recValid}, 32'h0);
  endtask

  task automatic runSpill(input bit retrig, input bit errBefore);
    @(negedge clk);
    spillTrig = 1;
    discIn = '0;
    @(negedge clk);
    for (int k = 0; k <= READ_LAST + 4; k++) begin
      int ph = k % PER;
      bit acq = (k <= ACQ_LAST);
      bit rd = (k >= READ_FIRST) && (k <= READ_LAST);
      logic expV = 1'b0;
      logic [31:0] expD = '0;
      check("R1 preReset", 32'(preReset), 32'(acq && ph >= INTEG));
      check("R2 plnClk", 32'(plnClk), 32'(acq && (ph == 0 || ph == PER / 2)));
      check("R3 digReset", 32'(digReset), 32'(acq && ph == INTEG + RST / 2));
      check("R4 muxClk", 32'(muxClk), 32'(rd && ((k - READ_FIRST) % DIV) < DIV / 2));
      check("R4 busy", 32'(busy), 32'(k <= READ_LAST));
      check("R9 busyErr", 32'(busyErr), 32'(errBefore || (retrig && k >= 51)));
      if (k >= READ_FIRST + DIV && (k - READ_FIRST - DIV) % DIV == 0 &&
          (k - READ_FIRST - DIV) / DIV < N_SAMPLES) begin
        int n = (k - READ_FIRST - DIV) / DIV;
        expV = 1'b1;
        expD = {16'(n / NCH), 1'b0, 5'(n % NCH), adcOf(k - 1)};
      end
      for (int h = 0; h < N_HITS; h++)
        if (HIT_EXPK[h] == k) begin
          expV = 1'b1;
          expD = {16'(HIT_AT[h]), 1'b1, 5'(HIT_LINE[h]), 10'b0};
        end
      // R5 sample records, R6 stamps, R7 ignored edges, R8 ordering
      check("R5/R6/R7/R8 recValid", 32'(recValid), 32'(expV));
      if (expV) check("R5/R6/R8 recData", recData, expD);
      spillTrig = retrig && (k == 50);
      discIn = '0;
      for (int h = 0; h < N_HITS; h++)
        if (k >= HIT_AT[h] && k < HIT_AT[h] + 2) discIn[HIT_LINE[h]] = 1'b1;
      adcData = adcOf(k);
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checkIdleOutputs("R10 reset outputs");
    check("R10 busyErr in reset", 32'(busyErr), 32'h0);
    rstN = 1;
    // R7: edges while idle give no record
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      discIn = NDISC'(k);
      check("R7 idle edges ignored", 32'(recValid), 32'h0);
    end
    discIn = '0;
    repeat (3) @(negedge clk);
    check("R7 idle edges ignored", 32'(recValid), 32'h0);
    runSpill(1'b1, 1'b0);
    runSpill(1'b0, 1'b1);
    // R10: reset in the middle of a spill clears everything
    @(negedge clk);
    spillTrig = 1;
    @(negedge clk);
    spillTrig = 0;
    repeat (5) @(negedge clk);
    spillTrig = 1;
    @(negedge clk);
    spillTrig = 0;
    check("R9 busyErr set", 32'(busyErr), 32'h1);
    rstN = 0;
    @(negedge clk);
    checkIdleOutputs("R10 mid-spill reset");
    check("R10 busyErr cleared", 32'(busyErr), 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule